// File: doc/BRIEF.md
# SDR Memory Command Front-End

This block is the control front end on the device side of a single-data-rate synchronous DRAM-style memory. Every rising clock edge it samples a chip select, three active-low command strobes, a bank select and a multiplexed address bus. From these it decodes bank activation, read, write, precharge and mode-register load. It captures the row on activation and the starting column on a read or write, then runs a burst column counter. It also keeps a per-bank open/idle record and applies the clock-enable rules: clock freezing while work is pending, and power-down when the device is idle.

Outputs are registered. Each accepted command produces a one-cycle strobe in the cycle after the edge that sampled it. An illegal command produces a separate strobe and otherwise has no effect. The array, the data path and refresh sit elsewhere and consume these outputs.

Top module: `sdr_cmd_frontend`

## Requirements
- R1: With chip select low at a rising edge, the strobe triple {ras_n, cas_n, we_n} selects the command: 011 activate, 101 read, 100 write, 010 precharge, 000 mode load; 111 and every other triple are a no-op. An accepted command raises its own output strobe for exactly the one cycle after that edge, and at most one command strobe is high at a time.
- R2: With chip select high, no command is accepted whatever the strobes carry, and a burst already running keeps stepping its column and finishes normally.
- R3: Activate of an idle bank latches row_addr from addr[ROW_W-1:0] and marks bank ba open in bank_open. Activate of an already open bank raises cmd_illegal and changes nothing.
- R4: Read or write to an open bank latches col_addr from addr[COL_W-1:0], where COL_W is 6 when WIDE_X32 is 0 and 5 otherwise. Read or write to an idle bank raises cmd_illegal and is ignored.
- R5: Address bit 10 selects the variant. On read or write it requests auto-precharge, and on precharge it closes every bank instead of bank ba. auto_pre repeats that bit beside the read, write or precharge strobe.
- R6: A burst of length BL keeps burst_active high for BL enabled cycles, beginning the cycle after the read or write. On each following enabled edge the column advances by one and wraps inside the BL-aligned block. Burst-length code addr[2:0] from the mode load means: 0 gives 1, 1 gives 2, 2 gives 4, any other value gives 8.
- R7: A burst with auto-precharge closes its bank on the enabled edge that ends the burst. A read or write issued while such a burst runs raises cmd_illegal and is ignored.
- R8: Mode load is accepted only when every bank is idle, and then it stores the burst-length code. Otherwise it raises cmd_illegal and the stored burst length is unchanged.
- R9: If cke is sampled low at an enabled edge while any bank is open or a burst runs, that edge is processed normally and the next edge is masked. On a masked edge no state changes, no command is taken, and all strobes are low.
- R10: If cke is sampled low at an enabled edge while all banks are idle and no burst runs, power_down rises, and that edge's command is ignored. power_down stays high until an edge samples cke high. That edge clears power_down and also ignores its command.
- R11: After synchronous reset all strobes, bank_open, burst_active, power_down, row_addr and col_addr are zero, and the burst length is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable, sampled each edge |
| cs_n | input | 1 | Active-low chip select |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write-enable strobe, active low |
| ba | input | BANK_W | Bank select |
| addr | input | ADDR_W | Multiplexed row/column/mode address |
| cmd_act | output | 1 | Activate accepted |
| cmd_read | output | 1 | Read accepted |
| cmd_write | output | 1 | Write accepted |
| cmd_pre | output | 1 | Precharge accepted |
| cmd_mode | output | 1 | Mode load accepted |
| cmd_illegal | output | 1 | Command rejected |
| auto_pre | output | 1 | Variant bit of the accepted read/write/precharge |
| row_addr | output | ROW_W | Last latched row |
| col_addr | output | COL_W | Current burst column |
| burst_active | output | 1 | Burst in progress |
| bank_open | output | NUM_BANKS | Per-bank open flag |
| power_down | output | 1 | Power-down state |

## Verification
The bench builds the block with four banks and 6-bit columns (WIDE_X32 = 0). This makes the 2-bit bank select, the precharge of a single bank next to other open banks, and column wrapping inside 4- and 8-beat blocks observable. A behavioural model replays the same stimulus and is compared with every output on every cycle. The stimulus covers deselected bursts, back-to-back and interrupted bursts, masked edges that land inside a burst, and power-down entered and left while commands are presented.

// File: rtl/sdr_cmd_pkg.sv
package sdr_cmd_pkg;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_ACT,
        OP_RD,
        OP_WR,
        OP_PRE,
        OP_MRS
    } op_e;

    // address bit carrying the auto-precharge / all-bank variant
    localparam int VARIANT_BIT = 10;

    typedef struct packed {
        logic act;
        logic rd;
        logic wr;
        logic pre;
        logic mrs;
        logic bad;
        logic ap;
    } strobe_t;

    function automatic op_e decode_op(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
        op_e r;
        if (cs_n) begin
            r = OP_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  r = OP_ACT;
                3'b101:  r = OP_RD;
                3'b100:  r = OP_WR;
                3'b010:  r = OP_PRE;
                3'b000:  r = OP_MRS;
                default: r = OP_NOP;
            endcase
        end
        return r;
    endfunction

    function automatic logic [3:0] burst_len(input logic [2:0] code);
        logic [3:0] r;
        case (code)
            3'd0:    r = 4'd1;
            3'd1:    r = 4'd2;
            3'd2:    r = 4'd4;
            default: r = 4'd8;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
    import sdr_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output op_e  op
);

    always_comb begin
        op = decode_op(cs_n, ras_n, cas_n, we_n);
    end

endmodule

// File: rtl/sdr_cke_ctrl.sv
module sdr_cke_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  logic idle,
    output logic run,
    output logic power_down
);

    logic cke_q;
    logic pd_q;
    logic enter_pd;

    assign enter_pd   = !pd_q && cke_q && !cke && idle;
    assign run        = !pd_q && cke_q && !enter_pd;
    assign power_down = pd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q <= 1'b1;
            pd_q  <= 1'b0;
        end else if (pd_q) begin
            if (cke) begin
                pd_q  <= 1'b0;
                cke_q <= 1'b1;
            end
        end else if (enter_pd) begin
            pd_q  <= 1'b1;
            cke_q <= 1'b0;
        end else begin
            cke_q <= cke;
        end
    end

endmodule

// File: rtl/sdr_bank_tracker.sv
module sdr_bank_tracker
    import sdr_cmd_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  op_e                  op,
    input  logic [BANK_W-1:0]    ba,
    input  logic                 all_sel,
    input  logic                 close_req,
    input  logic [BANK_W-1:0]    close_bank,
    input  logic                 ap_busy,
    output logic [NUM_BANKS-1:0] open_q,
    output logic                 act_ok,
    output logic                 rdwr_ok,
    output logic                 mrs_ok
);

    logic [NUM_BANKS-1:0] open_d;

    assign act_ok  = !open_q[ba];
    assign rdwr_ok = open_q[ba] && !ap_busy;
    assign mrs_ok  = (open_q == '0);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (ba == BANK_W'(b));
        always_comb begin
            open_d[b] = open_q[b];
            if (run) begin
                if (close_req && close_bank == BANK_W'(b))
                    open_d[b] = 1'b0;
                if (op == OP_PRE && (all_sel || hit))
                    open_d[b] = 1'b0;
                else if (op == OP_ACT && act_ok && hit)
                    open_d[b] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) open_q <= '0;
        else     open_q <= open_d;
    end

endmodule

// File: rtl/sdr_burst_ctr.sv
module sdr_burst_ctr #(
    parameter int COL_W  = 6,
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              launch,
    input  logic [COL_W-1:0]  col_in,
    input  logic [3:0]        bl,
    input  logic              ap_in,
    input  logic [BANK_W-1:0] bank_in,
    output logic [COL_W-1:0]  col_q,
    output logic              active_q,
    output logic              ap_busy,
    output logic              close_req,
    output logic [BANK_W-1:0] close_bank
);

    logic [2:0]        rem_q;
    logic [COL_W-1:0]  mask_q;
    logic              ap_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  col_step;
    logic              last;

    assign last       = (rem_q == 3'd0);
    assign col_step   = (col_q & ~mask_q) | ((col_q + 1'b1) & mask_q);
    assign ap_busy    = active_q && ap_q;
    assign close_req  = run && active_q && last && ap_q;
    assign close_bank = bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q    <= '0;
            rem_q    <= '0;
            mask_q   <= '0;
            ap_q     <= 1'b0;
            bank_q   <= '0;
            active_q <= 1'b0;
        end else if (run) begin
            if (launch) begin
                col_q    <= col_in;
                rem_q    <= 3'(bl - 4'd1);
                mask_q   <= COL_W'(bl - 4'd1);
                ap_q     <= ap_in;
                bank_q   <= bank_in;
                active_q <= 1'b1;
            end else if (active_q) begin
                if (last) begin
                    active_q <= 1'b0;
                    ap_q     <= 1'b0;
                end else begin
                    col_q <= col_step;
                    rem_q <= rem_q - 3'd1;
                end
            end
        end
    end

endmodule

// File: rtl/sdr_cmd_frontend.sv
module sdr_cmd_frontend
    import sdr_cmd_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ROW_W     = 13,
    parameter int ADDR_W    = 13,
    parameter bit WIDE_X32  = 1'b0,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int COL_W    = WIDE_X32 ? 5 : 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BANK_W-1:0]    ba,
    input  logic [ADDR_W-1:0]    addr,
    output logic                 cmd_act,
    output logic                 cmd_read,
    output logic                 cmd_write,
    output logic                 cmd_pre,
    output logic                 cmd_mode,
    output logic                 cmd_illegal,
    output logic                 auto_pre,
    output logic [ROW_W-1:0]     row_addr,
    output logic [COL_W-1:0]     col_addr,
    output logic                 burst_active,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic                 power_down
);

    op_e               op;
    logic              run;
    logic              idle;
    logic              act_ok, rdwr_ok, mrs_ok;
    logic              ap_busy, close_req;
    logic [BANK_W-1:0] close_bank;
    logic              launch;
    logic              variant;
    logic [2:0]        mode_q;
    logic [ROW_W-1:0]  row_q;
    strobe_t           stb_d, stb_q;

    assign variant = addr[VARIANT_BIT];
    assign idle    = (bank_open == '0) && !burst_active;

    sdr_cmd_decode u_dec (
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .op   (op)
    );

    sdr_cke_ctrl u_cke (
        .clk       (clk),
        .rst       (rst),
        .cke       (cke),
        .idle      (idle),
        .run       (run),
        .power_down(power_down)
    );

    sdr_bank_tracker #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_banks (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .op        (op),
        .ba        (ba),
        .all_sel   (variant),
        .close_req (close_req),
        .close_bank(close_bank),
        .ap_busy   (ap_busy),
        .open_q    (bank_open),
        .act_ok    (act_ok),
        .rdwr_ok   (rdwr_ok),
        .mrs_ok    (mrs_ok)
    );

    assign launch = run && (op == OP_RD || op == OP_WR) && rdwr_ok;

    sdr_burst_ctr #(.COL_W(COL_W), .BANK_W(BANK_W)) u_burst (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .launch    (launch),
        .col_in    (addr[COL_W-1:0]),
        .bl        (burst_len(mode_q)),
        .ap_in     (variant),
        .bank_in   (ba),
        .col_q     (col_addr),
        .active_q  (burst_active),
        .ap_busy   (ap_busy),
        .close_req (close_req),
        .close_bank(close_bank)
    );

    always_comb begin
        stb_d     = '0;
        stb_d.act = run && op == OP_ACT && act_ok;
        stb_d.rd  = launch && op == OP_RD;
        stb_d.wr  = launch && op == OP_WR;
        stb_d.pre = run && op == OP_PRE;
        stb_d.mrs = run && op == OP_MRS && mrs_ok;
        stb_d.bad = run && ((op == OP_ACT && !act_ok) ||
                            ((op == OP_RD || op == OP_WR) && !rdwr_ok) ||
                            (op == OP_MRS && !mrs_ok));
        stb_d.ap  = (stb_d.rd || stb_d.wr || stb_d.pre) && variant;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q  <= '0;
            row_q  <= '0;
            mode_q <= '0;
        end else begin
            stb_q <= stb_d;
            if (stb_d.act) row_q  <= addr[ROW_W-1:0];
            if (stb_d.mrs) mode_q <= addr[2:0];
        end
    end

    assign cmd_act     = stb_q.act;
    assign cmd_read    = stb_q.rd;
    assign cmd_write   = stb_q.wr;
    assign cmd_pre     = stb_q.pre;
    assign cmd_mode    = stb_q.mrs;
    assign cmd_illegal = stb_q.bad;
    assign auto_pre    = stb_q.ap;
    assign row_addr    = row_q;

endmodule

// File: rtl/sdr_cmd_checker.sv
module sdr_cmd_checker #(
    parameter int NUM_BANKS = 2,
    parameter int ROW_W     = 13,
    parameter int ADDR_W    = 13
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cs_n,
    input logic [ADDR_W-1:0]    addr,
    input logic                 cmd_act,
    input logic                 cmd_read,
    input logic                 cmd_write,
    input logic                 cmd_pre,
    input logic                 cmd_mode,
    input logic                 cmd_illegal,
    input logic                 auto_pre,
    input logic [ROW_W-1:0]     row_addr,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic                 power_down
);

    logic any_stb;
    assign any_stb = cmd_act | cmd_read | cmd_write | cmd_pre | cmd_mode | cmd_illegal;

    assert_one_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_act, cmd_read, cmd_write, cmd_pre, cmd_mode, cmd_illegal}));

    assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !any_stb);

    assert_row_capture_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_act |-> row_addr == $past(addr[ROW_W-1:0]));

    assert_variant_owner_R5: assert property (@(posedge clk) disable iff (rst)
        auto_pre |-> (cmd_read || cmd_write || cmd_pre));

    assert_mode_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_mode |-> $past(bank_open) == '0);

    assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        power_down |-> !any_stb);

endmodule

bind sdr_cmd_frontend sdr_cmd_checker #(
    .NUM_BANKS(NUM_BANKS),
    .ROW_W    (ROW_W),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .addr       (addr),
    .cmd_act    (cmd_act),
    .cmd_read   (cmd_read),
    .cmd_write  (cmd_write),
    .cmd_pre    (cmd_pre),
    .cmd_mode   (cmd_mode),
    .cmd_illegal(cmd_illegal),
    .auto_pre   (auto_pre),
    .row_addr   (row_addr),
    .bank_open  (bank_open),
    .power_down (power_down)
);

// File: tb/sdr_cmd_frontend_tb_top.sv
`timescale 1ns/1ps
module sdr_cmd_frontend_tb_top;

    localparam int NB   = 4;
    localparam int COLW = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;

    logic        cmd_act, cmd_read, cmd_write, cmd_pre, cmd_mode, cmd_illegal, auto_pre;
    logic [12:0] row_addr;
    logic [5:0]  col_addr;
    logic        burst_active, power_down;
    logic [3:0]  bank_open;

    always #2.5 clk = ~clk;

    sdr_cmd_frontend #(.NUM_BANKS(NB), .ROW_W(13), .ADDR_W(13), .WIDE_X32(1'b0)) dut_i (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr),
        .cmd_act(cmd_act), .cmd_read(cmd_read), .cmd_write(cmd_write), .cmd_pre(cmd_pre),
        .cmd_mode(cmd_mode), .cmd_illegal(cmd_illegal), .auto_pre(auto_pre),
        .row_addr(row_addr), .col_addr(col_addr), .burst_active(burst_active),
        .bank_open(bank_open), .power_down(power_down)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    string ph = "R11";

    // behavioural reference state
    bit m_open[NB];
    int m_row, m_col, m_rem, m_mask, m_bank, m_bl;
    bit m_busy, m_ap, m_pd, m_ckeq;
    bit e_act, e_rd, e_wr, e_pre, e_mrs, e_bad, e_ap;

    function automatic int len_of(int code);
        if (code == 0) return 1;
        if (code == 1) return 2;
        if (code == 2) return 4;
        return 8;
    endfunction

    task automatic model_reset();
        foreach (m_open[i]) m_open[i] = 0;
        m_row = 0; m_col = 0; m_rem = 0; m_mask = 0; m_bank = 0; m_bl = 1;
        m_busy = 0; m_ap = 0; m_pd = 0; m_ckeq = 1;
        {e_act, e_rd, e_wr, e_pre, e_mrs, e_bad, e_ap} = '0;
    endtask

    task automatic model_step(bit k, bit cs, bit r, bit c, bit w, int b, int a);
        int  op;
        bit  any_open, ap_busy, launch, v;
        bit  old_open[NB];
        {e_act, e_rd, e_wr, e_pre, e_mrs, e_bad, e_ap} = '0;
        if (m_pd) begin
            if (k) begin m_pd = 0; m_ckeq = 1; end
            return;
        end
        if (!m_ckeq) begin
            m_ckeq = k;
            return;
        end
        any_open = 0;
        foreach (m_open[i]) any_open |= m_open[i];
        if (!k && !any_open && !m_busy) begin
            m_pd = 1; m_ckeq = 0;
            return;
        end
        m_ckeq = k;
        op = 0;
        if (!cs) begin
            if ({r, c, w} == 3'b011) op = 1;
            else if ({r, c, w} == 3'b101) op = 2;
            else if ({r, c, w} == 3'b100) op = 3;
            else if ({r, c, w} == 3'b010) op = 4;
            else if ({r, c, w} == 3'b000) op = 5;
        end
        v = a[10];
        old_open = m_open;
        ap_busy = m_busy && m_ap;
        launch = (op == 2 || op == 3) && old_open[b] && !ap_busy;
        if (launch) begin
            m_col = a % 64; m_rem = m_bl - 1; m_mask = m_bl - 1;
            m_busy = 1; m_ap = v; m_bank = b;
        end else if (m_busy) begin
            if (m_rem == 0) begin
                if (m_ap) m_open[m_bank] = 0;
                m_busy = 0; m_ap = 0;
            end else begin
                m_col = ((m_col & ~m_mask) | ((m_col + 1) & m_mask)) % 64;
                m_rem--;
            end
        end
        case (op)
            1: if (!old_open[b]) begin m_open[b] = 1; m_row = a; e_act = 1; end
               else e_bad = 1;
            2, 3: if (launch) begin
                    if (op == 2) e_rd = 1; else e_wr = 1;
                    e_ap = v;
                  end else e_bad = 1;
            4: begin
                e_pre = 1; e_ap = v;
                if (v) foreach (m_open[i]) m_open[i] = 0;
                else m_open[b] = 0;
               end
            5: begin
                any_open = 0;
                foreach (old_open[i]) any_open |= old_open[i];
                if (!any_open) begin e_mrs = 1; m_bl = len_of(a % 8); end
                else e_bad = 1;
               end
            default: ;
        endcase
    endtask

    task automatic chk(string field, string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s [%s, phase %s] actual=%0h expected=%0h", req, field, ph, act, exp);
        end
    endtask

    task automatic compare_all();
        int ob = 0;
        foreach (m_open[i]) if (m_open[i]) ob |= (1 << i);
        chk("cmd_act",      "R1", cmd_act,      e_act);
        chk("cmd_read",     "R1", cmd_read,     e_rd);
        chk("cmd_write",    "R1", cmd_write,    e_wr);
        chk("cmd_pre",      "R1", cmd_pre,      e_pre);
        chk("cmd_mode",     "R8", cmd_mode,     e_mrs);
        chk("cmd_illegal",  "R4", cmd_illegal,  e_bad);
        chk("auto_pre",     "R5", auto_pre,     e_ap);
        chk("row_addr",     "R3", row_addr,     m_row);
        chk("col_addr",     "R6", col_addr,     m_col);
        chk("burst_active", "R6", burst_active, m_busy);
        chk("bank_open",    "R7", bank_open,    ob);
        chk("power_down",   "R10", power_down,  m_pd);
    endtask

    // one clock: drive at the falling edge, compare at the next falling edge
    task automatic step(bit k, bit cs, bit r, bit c, bit w, int b, int a);
        cke = k; cs_n = cs; ras_n = r; cas_n = c; we_n = w;
        ba = 2'(b); addr = 13'(a);
        model_step(k, cs, r, c, w, b, a);
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic nop(int n);
        for (int i = 0; i < n; i++) step(1, 0, 1, 1, 1, 0, 0);
    endtask
    task automatic desel(int n);
        // deselected with an activate pattern on the strobes
        for (int i = 0; i < n; i++) step(1, 1, 0, 1, 1, 2, 13'h0777);
    endtask
    task automatic act(int b, int row);     step(1, 0, 0, 1, 1, b, row);                 endtask
    task automatic rd(int b, int col, bit ap); step(1, 0, 1, 0, 1, b, col | (ap << 10)); endtask
    task automatic wr(int b, int col, bit ap); step(1, 0, 1, 0, 0, b, col | (ap << 10)); endtask
    task automatic pre(int b, bit all);     step(1, 0, 0, 1, 0, b, all << 10);           endtask
    task automatic mrs(int code);           step(1, 0, 0, 0, 0, 0, code);                endtask

    initial begin : watchdog
        #(5ns * 20000);
        n_fails++;
        $display("FAIL watchdog expired in phase %s", ph);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : stim
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cs_n = 1'b1;
        // R11: reset state
        ph = "R11";
        compare_all();
        chk("reset burst length via col wrap", "R11", m_bl, 1);

        ph = "R8";   mrs(2); nop(1);                     // BL 4
        ph = "R3";   act(1, 13'h1ABC); nop(1);
        ph = "R2";   rd(1, 6'h2E, 0); desel(5);          // burst 2E,2F,2C,2D under deselect
        ph = "R7";   wr(1, 6'h05, 1); rd(1, 0, 0); nop(5); // rd during auto burst is illegal
        ph = "R4";   rd(1, 0, 0);                        // bank closed now
        act(0, 13'h0123); act(0, 13'h0456);              // second activate illegal
        rd(0, 6'h3F, 0); mrs(3); nop(4);                 // mode load with open bank illegal
        ph = "R9";   rd(0, 6'h10, 0);
        step(0, 0, 1, 1, 1, 0, 0);                       // cke low, bank open
        step(1, 0, 0, 1, 1, 1, 13'h0999);                // masked: activate ignored
        step(0, 0, 1, 1, 1, 0, 0);
        step(0, 0, 1, 0, 1, 0, 6'h20);                   // masked, still low
        step(1, 0, 1, 0, 1, 0, 6'h21);                   // masked
        nop(4);
        ph = "R5";   pre(0, 1); act(1, 13'h0042); act(2, 13'h0043);
        pre(1, 0); nop(1); pre(3, 1); nop(2);
        ph = "R10";  step(0, 0, 0, 1, 1, 0, 13'h0055);   // enters power-down
        step(0, 0, 0, 1, 1, 0, 13'h0056);
        step(0, 0, 0, 0, 0, 0, 3);
        step(1, 0, 0, 1, 1, 2, 13'h0057);                // exit, ignored
        nop(1); act(2, 13'h0058); pre(0, 1); nop(1);
        ph = "R6";   mrs(3); act(1, 13'h0100); rd(1, 6'h2B, 1); nop(10);
        mrs(0); act(1, 13'h0101); rd(1, 7, 0); rd(1, 8, 0); nop(2);
        pre(1, 1); mrs(5); act(0, 13'h0102); wr(0, 6'h31, 0); nop(3);
        wr(0, 6'h1C, 0); nop(9);
        ph = "R1";   step(1, 0, 0, 0, 1, 0, 0);         // other triple acts as no-op
        step(1, 0, 1, 1, 0, 0, 0);
        nop(2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule